// File: doc/BRIEF.md
# Thermal Throttle Event Tracker

The block watches a single over-temperature trip line coming from a thermal sensor and turns it into a small set of throttle statistics. After a two-stage synchronizer, the trip line becomes a live status bit. Every transition of that status from 0 to 1 counts as one throttle episode. A sticky log bit records that a trip has happened and stays set until software lowers it with a one-cycle clear pulse.

A free-running millisecond strobe is used to time the episodes. On every strobe that arrives while the status is high, the block adds one to the running length of the current episode and one to the accumulated throttled time. The longest episode seen so far is updated as soon as the running length goes past it, so it can change while an episode is still in progress. The three statistics are read-only and are unaffected by the log clear. Only a reset returns them to zero, and they wrap modulo 2^STAT_W. A design can place one instance at core level and another at package level.

Top module: `thr_event_tracker`

## Requirements
- R1: While reset is asserted and after it is released, status_o, log_o, episodes_o, longest_ms_o and total_ms_o are all 0.
- R2: status_o equals trip_i as sampled at the rising clock edge two cycles earlier. This is a two-flip-flop synchronizer latency.
- R3: log_o goes to 1 on the clock edge after status_o goes from 0 to 1. It stays 1 after status_o returns to 0.
- R4: A one-cycle log_clr_i pulse clears log_o on the next edge when no new 0-to-1 status transition occurs in the same cycle.
- R5: If log_clr_i is high in the same cycle as a 0-to-1 status transition, the set wins and log_o stays 1.
- R6: episodes_o increments by exactly 1 on the edge after each 0-to-1 transition of status_o. A status that stays high adds nothing.
- R7: total_ms_o increments by 1 on every edge at which ms_tick_i is 1 and status_o is 1. Ticks while status_o is 0 have no effect.
- R8: The current episode length starts at 0 on a 0-to-1 status transition, counting a tick in that same cycle as 1. It advances on each tick while status_o is 1. longest_ms_o takes the running length on the same edge the length exceeds it, including mid-episode.
- R9: log_clr_i has no effect on episodes_o, longest_ms_o or total_ms_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Asynchronous over-temperature trip indication |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| log_clr_i | input | 1 | One-cycle software clear of the log bit |
| status_o | output | 1 | Live synchronized throttle status |
| log_o | output | 1 | Sticky trip log bit |
| episodes_o | output | STAT_W | Count of status 0-to-1 transitions |
| longest_ms_o | output | STAT_W | Longest episode length in ticks |
| total_ms_o | output | STAT_W | Accumulated ticks with status high |

## Verification
A trip change that the bench drives between edges appears on status_o after the second rising edge. log_o and episodes_o follow on the third edge. A tick or clear applied in a cycle shows its effect on total_ms_o, longest_ms_o or log_o after the very next edge. The bench drives inputs on the falling edge and steps an exact number of falling edges for each latency. It samples only there, so every comparison falls in the cycle where the result is first due. It also checks the cycle just before, where the result must not yet have appeared.

// File: rtl/thr_pkg.sv
package thr_pkg;
   // Event produced by the edge/log stage for the statistics stage.
   typedef struct packed {
      logic status;
      logic rise;
   } thr_evt_t;

   localparam int unsigned THR_MAX_STAT_W = 64;
   localparam int unsigned THR_MIN_SYNC   = 2;
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;

   if (STAGES < thr_pkg::THR_MIN_SYNC) begin : g_bad_stages
      $error("thr_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[0] <= 1'b0;
            else       chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[i] <= 1'b0;
            else       chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/thr_flag.sv
module thr_flag (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              status_i,
   input  logic              clr_i,
   output thr_pkg::thr_evt_t evt_o,
   output logic              log_o
);
   logic prev_q;
   logic log_q;
   logic rise;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= status_i;
   end

   assign rise = status_i & ~prev_q;

   // Set has priority over a simultaneous clear.
   always_ff @(posedge clk_i) begin
      if (rst_i)      log_q <= 1'b0;
      else if (rise)  log_q <= 1'b1;
      else if (clr_i) log_q <= 1'b0;
   end

   assign evt_o.status = status_i;
   assign evt_o.rise   = rise;
   assign log_o        = log_q;

   p_log_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (status_i && !prev_q) |=> log_q);

   p_clr_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i && !(status_i && !prev_q)) |=> !log_q);

   p_set_over_clr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i && status_i && !prev_q) |=> log_q);

   p_log_sticky_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (log_q && !clr_i) |=> log_q);
endmodule

// File: rtl/thr_stats.sv
module thr_stats #(
   parameter int unsigned STAT_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  thr_pkg::thr_evt_t evt_i,
   input  logic              tick_i,
   output logic [STAT_W-1:0] episodes_o,
   output logic [STAT_W-1:0] longest_o,
   output logic [STAT_W-1:0] total_o
);
   localparam logic [STAT_W-1:0] ONE  = STAT_W'(1);
   localparam logic [STAT_W-1:0] ZERO = '0;

   logic [STAT_W-1:0] count_q, longest_q, total_q, cur_q, cur_next;
   logic              live_tick;

   if (STAT_W < 2 || STAT_W > thr_pkg::THR_MAX_STAT_W) begin : g_bad_width
      $error("thr_stats: STAT_W out of range");
   end

   assign live_tick = evt_i.status & tick_i;

   always_comb begin
      cur_next = cur_q;
      if (evt_i.rise)     cur_next = live_tick ? ONE : ZERO;
      else if (live_tick) cur_next = cur_q + ONE;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q   <= '0;
         longest_q <= '0;
         total_q   <= '0;
         cur_q     <= '0;
      end else begin
         cur_q <= cur_next;
         if (evt_i.rise)           count_q   <= count_q + ONE;
         if (live_tick)            total_q   <= total_q + ONE;
         if (cur_next > longest_q) longest_q <= cur_next;
      end
   end

   assign episodes_o = count_q;
   assign longest_o  = longest_q;
   assign total_o    = total_q;

   p_count_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i.rise |=> (count_q == $past(count_q) + ONE));

   p_count_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !evt_i.rise |=> $stable(count_q));

   p_total_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !(evt_i.status && tick_i) |=> $stable(total_q));

   p_longest_cover_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      longest_q >= cur_q);
endmodule

// File: rtl/thr_event_tracker.sv
module thr_event_tracker #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_W      = 64
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              trip_i,
   input  logic              ms_tick_i,
   input  logic              log_clr_i,
   output logic              status_o,
   output logic              log_o,
   output logic [STAT_W-1:0] episodes_o,
   output logic [STAT_W-1:0] longest_ms_o,
   output logic [STAT_W-1:0] total_ms_o
);
   logic              status;
   thr_pkg::thr_evt_t evt;

   thr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (trip_i),
      .q_o   (status)
   );

   thr_flag u_flag (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .status_i (status),
      .clr_i    (log_clr_i),
      .evt_o    (evt),
      .log_o    (log_o)
   );

   thr_stats #(.STAT_W(STAT_W)) u_stats (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .evt_i      (evt),
      .tick_i     (ms_tick_i),
      .episodes_o (episodes_o),
      .longest_o  (longest_ms_o),
      .total_o    (total_ms_o)
   );

   assign status_o = status;

   p_clr_no_stats_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (log_clr_i && !ms_tick_i && !evt.rise) |=>
         ($stable(episodes_o) && $stable(total_ms_o) && $stable(longest_ms_o)));
endmodule

// File: tb/test_thr_event_tracker.sv
module test_thr_event_tracker;
   localparam int unsigned W = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          trip = 1'b0, tick = 1'b0, clr = 1'b0;
   logic          status, logb;
   logic [W-1:0]  episodes, longest, total;

   int n_chk = 0;
   int n_bad = 0;
   longint unsigned e_cnt = 0, e_tot = 0, e_max = 0;

   always #10 clk = ~clk;

   thr_event_tracker #(.SYNC_STAGES(2), .STAT_W(W)) i_thr_event_tracker (
      .clk_i(clk), .rst_i(rst), .trip_i(trip), .ms_tick_i(tick),
      .log_clr_i(clr), .status_o(status), .log_o(logb),
      .episodes_o(episodes), .longest_ms_o(longest), .total_ms_o(total)
   );

   task automatic chk(input string req, input longint unsigned act,
                      input longint unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick = 1'b1; step(1); tick = 1'b0;
      if (status) e_tot++;
   endtask

   task automatic check_stats(input string req);
      chk({req, " episodes"}, episodes, e_cnt);
      chk({req, " total"},    total,    e_tot);
      chk({req, " longest"},  longest,  e_max);
   endtask

   task automatic t_reset();
      step(2);
      chk("R1 status", status, 0);
      chk("R1 log", logb, 0);
      check_stats("R1");
      rst = 1'b0;
      step(1);
      chk("R1 status after release", status, 0);
      check_stats("R1 after release");
   endtask

   // R2 R3 R6: latency of status, log and count
   task automatic t_first_trip();
      trip = 1'b1;
      step(1);
      chk("R2 status not yet", status, 0);
      step(1);
      chk("R2 status after two edges", status, 1);
      chk("R3 log not yet", logb, 0);
      chk("R6 count not yet", episodes, 0);
      step(1); e_cnt++;
      chk("R3 log set", logb, 1);
      chk("R6 count one", episodes, e_cnt);
      step(5);
      chk("R6 held high no extra", episodes, e_cnt);
      trip = 1'b0;
      step(2);
      chk("R2 status low", status, 0);
      chk("R3 log sticky", logb, 1);
   endtask

   // R4 R9: clear lowers log, leaves statistics alone
   task automatic t_clear();
      clr = 1'b1; step(1); clr = 1'b0;
      chk("R4 log cleared", logb, 0);
      check_stats("R9 after clear");
   endtask

   // R5: clear in the rise cycle loses
   task automatic t_clear_vs_set();
      trip = 1'b1;
      step(2);
      clr = 1'b1; step(1); clr = 1'b0; e_cnt++;
      chk("R5 set wins", logb, 1);
      chk("R6 counted", episodes, e_cnt);
      trip = 1'b0; step(3);
   endtask

   // R7 R8: tick accounting and longest episode
   task automatic t_durations();
      pulse_tick(); pulse_tick();
      check_stats("R7 idle ticks ignored");
      trip = 1'b1; step(3); e_cnt++;
      for (int i = 0; i < 3; i++) pulse_tick();
      e_max = 3;
      check_stats("R8 first episode");
      trip = 1'b0; step(3);
      pulse_tick();
      check_stats("R7 low tick ignored");
      trip = 1'b1; step(2);
      // rise cycle: tick here counts as 1
      pulse_tick(); e_cnt++;
      pulse_tick();
      chk("R8 longest held at 3", longest, 3);
      chk("R7 total", total, e_tot);
      pulse_tick(); pulse_tick();
      e_max = 4;
      chk("R8 longest mid-episode", longest, e_max);
      pulse_tick(); e_max = 5;
      check_stats("R8 second episode");
      clr = 1'b1; step(1); clr = 1'b0;
      check_stats("R9 clear during episode");
      trip = 1'b0; step(3);
      trip = 1'b1; step(3); e_cnt++;
      pulse_tick();
      trip = 1'b0; step(3);
      chk("R8 short episode keeps max", longest, e_max);
      check_stats("R7 R6 final");
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20ns * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_first_trip();
      t_clear();
      t_clear_vs_set();
      t_durations();
      summary();
   end
endmodule